// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block is the digital front end of a two-channel 12-bit converter. A host drives three wires: a serial clock, a serial data line and an active-low select line that also acts as the load strobe. While select is low, each rising edge of the serial clock pushes one data bit into a 24-bit frame register. When select returns high, the whole frame is split into two 12-bit codes, one per channel, and both channel code registers are written in the same system-clock cycle.

All three serial wires are asynchronous to the block's system clock. They pass through a multi-stage synchronizer, and their edges are detected in the system-clock domain. The serial clock therefore has to be several times slower than the system clock. A one-cycle completion pulse marks each update of the codes. Reset clears both codes and the frame register to zero.

Top module: `dual_dac_loader`

## Requirements
- R1: A frame is 24 bits. The first 12 bits shifted after select falls form the channel A code, most significant bit first. The next 12 bits form the channel B code, also MSB first, so the final bit is channel B's LSB.
- R2: While select is low, each rising edge of the serial clock shifts exactly one data bit into the frame register, and that bit is the data line's value at the edge.
- R3: Serial clock edges that occur while select is high leave the frame register unchanged. A later load then transfers the earlier contents.
- R4: A rising edge on select copies the frame register into both channel codes in one cycle. At all other times both codes hold their values.
- R5: Reset clears both channel codes and the frame register to code 0, and holds the completion pulse low.
- R6: If more than 24 serial clock edges arrive in one select-low window, the codes come from the last 24 bits shifted.
- R7: If fewer than 24 edges arrive, the load transfers the frame register as it stands. The older bits move up by the number of bits shifted, and no length check is made.
- R8: `load_done` is high for exactly one system-clock cycle per select rising edge, in the cycle in which the new codes first appear.
- R9: With two synchronizer stages, the codes change at the third rising system-clock edge after the select pin rises, and not earlier.
- R10: Each code spans the full range 0 to 4095. All-ones and all-zeros frames load unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on serial clock rise |
| ser_sel_n | input | 1 | Active-low select; its rising edge loads the codes |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| load_done | output | 1 | One-cycle pulse when the codes update |

## Verification
The bench builds the block with its default parameters: 12-bit codes, one 24-bit frame and two synchronizer stages. The short frame lets random windows of 0 to 30 bits cover underlength, exact and overlength frames many times over. The two-stage synchronizer fixes the load latency at three system clocks, which the bench checks edge by edge. Serial clock bursts while select is high are mixed between frames so that edges which must be ignored occur often.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    // Synchronized view of the three serial wires
    typedef struct packed {
        logic sck;
        logic sdi;
        logic seln;
    } ser_pins_t;

    // Edge detector history
    typedef struct packed {
        logic sck_prev;
        logic seln_prev;
    } edge_state_t;

    localparam ser_pins_t PINS_IDLE = '{sck: 1'b0, sdi: 1'b0, seln: 1'b1};

endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dacld_edge.sv
module dacld_edge
    import dacld_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ser_pins_t pins_s,
    output logic      shift_en,
    output logic      load_en
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d.sck_prev  = pins_s.sck;
        st_d.seln_prev = pins_s.seln;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sck_prev: 1'b0, seln_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // Serial clock rises count only while select is low
    assign shift_en = pins_s.sck & ~st_q.sck_prev & ~pins_s.seln;
    assign load_en  = pins_s.seln & ~st_q.seln_prev;
endmodule

// File: rtl/dacld_shift.sv
module dacld_shift #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] frame_d, frame_q;

    always_comb begin
        frame_d = frame_q;
        if (shift_en) begin
            frame_d = {frame_q[FRAME_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else begin
            frame_q <= frame_d;
        end
    end

    assign frame = frame_q;
endmodule

// File: rtl/dacld_outreg.sv
module dacld_outreg #(
    parameter int CODE_W = 12,
    parameter int NUM_CH = 2,
    localparam int FRAME_W = CODE_W * NUM_CH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [FRAME_W-1:0]            frame,
    output logic [NUM_CH-1:0][CODE_W-1:0] codes,
    output logic                          done
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] code;
        logic                          done;
    } out_state_t;

    out_state_t st_d, st_q;
    logic [NUM_CH-1:0][CODE_W-1:0] slice;

    // Channel 0 is shifted first, so it sits in the top slice
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slice
        assign slice[ch] = frame[FRAME_W-1-ch*CODE_W -: CODE_W];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = load_en;
        if (load_en) begin
            st_d.code = slice;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign codes = st_q.code;
    assign done  = st_q.done;
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacld_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_sel_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              load_done
);
    localparam int NUM_CH  = 2;
    localparam int FRAME_W = CODE_W * NUM_CH;

    ser_pins_t pins_raw, pins_s;
    logic shift_en, load_en;
    logic [FRAME_W-1:0] frame_q;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    assign pins_raw = '{sck: ser_clk, sdi: ser_data, seln: ser_sel_n};

    dacld_sync #(
        .WIDTH  ($bits(ser_pins_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pins_raw),
        .sync_out(pins_s)
    );

    dacld_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_s  (pins_s),
        .shift_en(shift_en),
        .load_en (load_en)
    );

    dacld_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_in  (pins_s.sdi),
        .frame   (frame_q)
    );

    dacld_outreg #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_en(load_en),
        .frame  (frame_q),
        .codes  (codes),
        .done   (load_done)
    );

    assign code_a = codes[0];
    assign code_b = codes[1];
endmodule

// File: rtl/dacld_checker.sv
module dacld_checker #(
    parameter int CODE_W = 12,
    localparam int FRAME_W = 2 * CODE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CODE_W-1:0]  code_a,
    input logic [CODE_W-1:0]  code_b,
    input logic               load_done,
    input logic [FRAME_W-1:0] frame,
    input logic               shift_en,
    input logic               sel_s
);
    p_load_copies_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> {code_a, code_b} == $past(frame));

    p_one_bit_per_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shift_en) |-> frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0]));

    p_frozen_while_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame != $past(frame)) |-> !$past(sel_s));

    p_codes_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_a != $past(code_a)) || (code_b != $past(code_b))) |-> load_done);

    p_reset_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (code_a == '0 && code_b == '0 && frame == '0));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);
endmodule

bind dual_dac_loader dacld_checker #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_a   (code_a),
    .code_b   (code_b),
    .load_done(load_done),
    .frame    (frame_q),
    .shift_en (shift_en),
    .sel_s    (pins_s.seln)
);

// File: tb/dual_dac_loader_test.sv
module dual_dac_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int FW = 2 * CW;
    localparam int HALF = 3;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_sel_n = 1'b1;
    logic [CW-1:0] code_a, code_b;
    logic load_done;

    int vectors = 0, misses = 0, cycles = 0, done_seen = 0;
    logic [FW-1:0] model_sr = '0;
    logic [CW-1:0] exp_a = '0, exp_b = '0;

    dual_dac_loader #(.CODE_W(CW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_sel_n(ser_sel_n), .code_a(code_a), .code_b(code_b), .load_done(load_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (load_done) done_seen++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; the model shifts only while select is low
    task automatic send_bit(logic b);
        ser_data = b;
        wait_neg(HALF);
        ser_clk = 1'b1;
        if (!ser_sel_n) model_sr = {model_sr[FW-2:0], b};
        wait_neg(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic sel_low();
        ser_sel_n = 1'b0;
        wait_neg(HALF);
    endtask

    // Raise select, check latency, update, and pulse width
    task automatic load_and_check(string req);
        int d0;
        d0 = done_seen;
        ser_sel_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 codes before third edge", {8'h0, code_a, code_b}, {8'h0, exp_a, exp_b});
        @(posedge clk); @(negedge clk);
        exp_a = model_sr[FW-1:CW];
        exp_b = model_sr[CW-1:0];
        chk({req, " code_a"}, code_a, exp_a);
        chk({req, " code_b"}, code_b, exp_b);
        chk("R8 done high with update", load_done, 1'b1);
        wait_neg(1);
        chk("R8 done one cycle", load_done, 1'b0);
        wait_neg(HALF);
        chk("R8 one pulse per load", done_seen - d0, 1);
        chk("R4 codes held after load", {8'h0, code_a, code_b}, {8'h0, exp_a, exp_b});
    endtask

    task automatic send_frame(logic [CW-1:0] a, logic [CW-1:0] b, string req);
        logic [FW-1:0] f;
        f = {a, b};
        sel_low();
        for (int i = FW - 1; i >= 0; i--) send_bit(f[i]);
        load_and_check(req);
    endtask

    task automatic noise_high(int n);
        for (int i = 0; i < n; i++) send_bit(1'($urandom));
    endtask

    initial begin
        void'($urandom(32'h1D0C_5EED));
        wait_neg(4);
        chk("R5 reset code_a", code_a, 0);
        chk("R5 reset code_b", code_b, 0);
        chk("R5 reset done", load_done, 0);
        rst_n = 1'b1;
        wait_neg(4);
        chk("R5 no load after reset", done_seen, 0);

        // R5/R7: empty window transfers the cleared frame register
        sel_low();
        load_and_check("R5 empty frame after reset");

        send_frame(12'hABC, 12'h123, "R1 order A then B");
        send_frame(12'hFFF, 12'h000, "R10 full scale A zero B");
        send_frame(12'h000, 12'hFFF, "R10 zero A full scale B");

        // R3: edges while select is high are ignored
        noise_high(9);
        chk("R3 no load from high-side edges", {8'h0, code_a, code_b}, {8'h0, exp_a, exp_b});
        sel_low();
        load_and_check("R3 frame untouched while high");

        // R6: 30 bits, last 24 kept
        sel_low();
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        for (int i = FW - 1; i >= 0; i--) send_bit(i[0]);
        load_and_check("R6 overlength keeps last 24");

        // R7: 5 bits only
        sel_low();
        for (int i = 0; i < 5; i++) send_bit(1'(i < 3));
        load_and_check("R7 short frame partial shift");

        // R2: random windows of 0..30 bits with high-side noise
        for (int k = 0; k < 40; k++) begin
            int n;
            noise_high(int'($urandom_range(0, 3)));
            n = int'($urandom_range(0, 30));
            sel_low();
            for (int i = 0; i < n; i++) send_bit(1'($urandom));
            load_and_check("R2 random window");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule